// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a single-port synchronous static memory that can accept a new read or write on every enabled clock edge, in any order, without an idle cycle between a read and a write. Reads are flow-through: the address captured at an edge selects the word that appears on the read data port during the cycle that edge begins. Writes are late: the address, the write command and the byte strobes are captured at one edge, and the data for them is taken at the next enabled edge. With this split, a read slot and a write slot can follow each other back to back on a shared data bus.

Operations start on a load edge. A load edge needs the clock enable active, the advance/load input low, and all three chip selects active. Continue edges keep the current operation type and take the address presented at that edge. A separate burst counter supplies that address. While the clock enable is inactive the whole core is frozen.

Top module: `zt_sram`

## Requirements
- R1: At an enabled edge with `adv_ld_n` low and any chip select inactive (`cs0_n`=1, `cs1`=0 or `cs2_n`=1), the core deselects: in the following cycle `rd_valid` is 0 and `rd_data` is 0.
- R2: At an edge with `cke_n` high, every input other than `oe_n` is ignored and no state changes. `rd_data` and `rd_valid` keep their values and the memory is not written.
- R3: At an enabled load edge with all selects active and `wr_n`=1, a read starts. During the next cycle `rd_valid`=1 and `rd_data` holds the word at the address captured at that edge, provided `oe_n`=0.
- R4: At an enabled load edge with all selects active and `wr_n`=0, a write is registered. The word stored is the `wr_data` presented at the next enabled edge, not the data present at the command edge.
- R5: Bit i of `lane_wr_n` (low = write) enables byte lane i, which is `wr_data[8i+7:8i]`. All strobes high makes the write a no-op. All strobes low writes the whole word.
- R6: At an enabled edge with `adv_ld_n` high after a read or write, the same operation type continues at the address on `addr`, whatever the chip selects are.
- R7: At an enabled edge with `adv_ld_n` high after a deselect, the core stays deselected (`rd_valid`=0).
- R8: `oe_n` high forces `rd_valid` to 0 and `rd_data` to 0 in the same cycle.
- R9: A read that immediately follows a write to the same address returns the newly written lanes merged with the unchanged old lanes.
- R10: A write that is pending when `cke_n` goes high stays pending. It completes at the next enabled edge with the `wr_data` present at that edge.
- R11: After reset the core is deselected with no pending write, and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv_ld_n | input | 1 | Low = load new operation, high = continue |
| wr_n | input | 1 | Low = write, high = read (sampled on load) |
| lane_wr_n | input | LANES | Per-byte write strobes, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Word address |
| wr_data | input | LANES*8 | Write data, taken one enabled edge after the command |
| rd_data | output | LANES*8 | Read data, zero when not driving |
| rd_valid | output | 1 | High when read data is being driven |

## Verification
The bench builds the core with `ADDR_W`=6 and `LANES`=2: 64 words of two byte lanes each. That size lets it write and read back every address in unbroken streams of loads. It then sweeps all four strobe patterns through write/read pairs at the same address. It also steps continue bursts, clock-enable holds and deselect variants on the same small array, and predicts every read from its own mirror of the memory.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke_n,
  input  logic                 cs0_n,
  input  logic                 cs1,
  input  logic                 cs2_n,
  input  logic                 adv_ld_n,
  input  logic                 wr_n,
  input  logic [LANES-1:0]     lane_wr_n,
  input  logic                 oe_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LANES*8-1:0]   wr_data,
  output logic [LANES*8-1:0]   rd_data,
  output logic                 rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = LANES * 8;

  typedef enum logic [1:0] {OP_DESEL, OP_READ, OP_WRITE} op_t;

  logic [DW-1:0]     mem [DEPTH];
  op_t               op_q, op_d;
  logic              rd_q;
  logic [ADDR_W-1:0] ra_q;
  logic              wp_q;
  logic [ADDR_W-1:0] wa_q;
  logic [LANES-1:0]  wl_q;
  logic              sel;

  assign sel = !cs0_n && cs1 && !cs2_n;

  always_comb begin
    if (adv_ld_n)  op_d = op_q;
    else if (!sel) op_d = OP_DESEL;
    else           op_d = wr_n ? OP_READ : OP_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_DESEL;
      rd_q <= 1'b0;
      ra_q <= '0;
      wp_q <= 1'b0;
      wa_q <= '0;
      wl_q <= '1;
    end else if (!cke_n) begin
      op_q <= op_d;
      rd_q <= (op_d == OP_READ);
      ra_q <= addr;
      wp_q <= (op_d == OP_WRITE);
      wa_q <= addr;
      wl_q <= lane_wr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!cke_n && wp_q) begin
      for (int i = 0; i < LANES; i++)
        if (!wl_q[i]) mem[wa_q][i*8 +: 8] <= wr_data[i*8 +: 8];
    end
  end

  assign rd_valid = rd_q && !oe_n;
  assign rd_data  = rd_valid ? mem[ra_q] : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cke_n,
  input logic               cs0_n,
  input logic               cs1,
  input logic               cs2_n,
  input logic               adv_ld_n,
  input logic               wr_n,
  input logic               oe_n,
  input logic [LANES*8-1:0] rd_data,
  input logic               rd_valid
);
  logic sel_c;
  assign sel_c = !cs0_n && cs1 && !cs2_n;

  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld_n && !sel_c) |=> !rd_valid);

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && !oe_n) |=> (oe_n || ($stable(rd_valid) && $stable(rd_data))));

  a_r3_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld_n && sel_c && wr_n) |=> (rd_valid || oe_n));

  a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld_n && sel_c && !wr_n) |=> !rd_valid);

  a_r8_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rd_valid && rd_data == '0));
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1),
  .cs2_n(cs2_n), .adv_ld_n(adv_ld_n), .wr_n(wr_n), .oe_n(oe_n),
  .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb;
  localparam int AW = 6, LN = 2, DW = LN * 8, N = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic cke_n = 0, cs0_n = 1, cs1 = 0, cs2_n = 1, adv_ld_n = 0, wr_n = 1, oe_n = 0;
  logic [LN-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  zt_sram #(.ADDR_W(AW), .LANES(LN)) u_dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  logic [DW-1:0] mdl [N];
  int bop = 0;
  bit pw = 0, exp_rd = 0;
  int pa = 0, ea = 0;
  logic [LN-1:0] pl = '1;

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'(a * 257 + k * 4660 + 16'h1c3d);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] got_d, logic got_v, logic [DW-1:0] ex_d, logic ex_v);
    tests++;
    if (got_d !== ex_d || got_v !== ex_v) begin
      fails++;
      $display("FAIL %s: rd_data=%h rd_valid=%b expected %h %b", tag, got_d, got_v, ex_d, ex_v);
    end
  endtask

  task automatic step(string tag, bit ce, bit s0n, bit s1, bit s2n, bit adv, bit we,
                      logic [LN-1:0] bw, bit oe, int a, logic [DW-1:0] d);
    int cur;
    @(negedge clk);
    cke_n = ce; cs0_n = s0n; cs1 = s1; cs2_n = s2n; adv_ld_n = adv; wr_n = we;
    lane_wr_n = bw; oe_n = oe; addr = AW'(a); wr_data = d;
    @(posedge clk);
    if (!ce) begin
      if (pw) for (int i = 0; i < LN; i++) if (!pl[i]) mdl[pa][i*8 +: 8] = d[i*8 +: 8];
      if (adv) cur = bop;
      else if (s0n || !s1 || s2n) cur = 0;
      else cur = we ? 1 : 2;
      bop = cur; pw = (cur == 2); pa = a; pl = bw; exp_rd = (cur == 1); ea = a;
    end
    #5;
    if (exp_rd && !oe) chk(tag, rd_data, rd_valid, mdl[ea], 1'b1);
    else chk(tag, rd_data, rd_valid, '0, 1'b0);
  endtask

  task automatic ld_wr(string t, int a, logic [LN-1:0] bw, logic [DW-1:0] d);
    step(t, 0, 0, 1, 0, 0, 0, bw, 0, a, d);
  endtask
  task automatic ld_rd(string t, int a, logic [DW-1:0] d, bit oe);
    step(t, 0, 0, 1, 0, 0, 1, '1, oe, a, d);
  endtask
  task automatic desel(string t, logic [DW-1:0] d);
    step(t, 0, 1, 1, 0, 0, 1, '1, 0, 0, d);
  endtask

  initial begin
    #(20 * 200000);
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #45 rst_n = 1;
    #1 chk("R11 reset idle", rd_data, rd_valid, '0, 1'b0);

    // R4 full sweep of back-to-back late writes
    for (int a = 0; a < N; a++) ld_wr("R4 sweep write", a, '0, a == 0 ? 16'hdead : pat(a - 1, 0));
    desel("R4 last data", pat(N - 1, 0));
    // R3 full sweep of back-to-back reads
    for (int a = 0; a < N; a++) ld_rd("R3 sweep read", a, '0, 0);
    for (int a = 0; a < N; a++) begin
      tests++;
      if (mdl[a] !== pat(a, 0)) begin
        fails++; $display("FAIL R4 model a=%0d: %h expected %h", a, mdl[a], pat(a, 0));
      end
    end

    // R5 R9 write/read alternation with all strobe patterns
    for (int a = 0; a < 16; a++) begin
      ld_wr("R5 strobe write", a, LN'(a), 16'hffff);
      ld_rd("R9 read after write", a, pat(a, 3), 0);
    end
    desel("R1 after alternation", 16'h0);

    // R1 each select inactive, R7 continue deselect
    step("R1 cs0_n high", 0, 1, 1, 0, 0, 1, '1, 0, 3, 0);
    step("R1 cs1 low",    0, 0, 0, 0, 0, 1, '1, 0, 3, 0);
    step("R1 cs2_n high", 0, 0, 1, 1, 0, 1, '1, 0, 3, 0);
    step("R7 continue deselect", 0, 0, 1, 0, 1, 1, '1, 0, 4, 0);
    step("R7 continue deselect", 0, 0, 1, 0, 1, 0, '0, 0, 5, 0);

    // R6 continue bursts
    ld_rd("R6 burst read load", 40, 0, 0);
    step("R6 burst read cont", 0, 1, 0, 1, 1, 0, '0, 0, 41, 0);
    step("R6 burst read cont", 0, 1, 0, 1, 1, 0, '0, 0, 42, 0);
    ld_wr("R6 burst write load", 50, '0, 0);
    step("R6 burst write cont", 0, 1, 1, 0, 1, 1, '0, 0, 51, pat(50, 7));
    step("R6 burst write cont", 0, 1, 1, 0, 1, 1, '0, 0, 52, pat(51, 7));
    desel("R6 burst write end", pat(52, 7));
    for (int a = 50; a < 53; a++) ld_rd("R6 burst readback", a, 0, 0);

    // R2 clock enable hold
    ld_rd("R2 read before hold", 5, 0, 0);
    step("R2 held", 1, 0, 1, 0, 0, 0, '0, 0, 6, 16'hbeef);
    step("R2 held", 1, 1, 0, 1, 1, 1, '0, 0, 7, 16'hbeef);
    ld_rd("R2 nothing written", 6, 0, 0);

    // R10 pending write across hold
    ld_wr("R10 write cmd", 30, 2'b00, 16'h1111);
    step("R10 hold junk", 1, 0, 1, 0, 0, 1, '1, 0, 31, 16'h2222);
    step("R10 hold junk", 1, 0, 1, 0, 0, 1, '1, 0, 31, 16'h3333);
    desel("R10 data edge", 16'ha5c3);
    ld_rd("R10 readback", 30, 0, 0);

    // R8 output enable
    ld_rd("R8 oe high", 30, 0, 1);
    step("R8 oe low hold", 1, 0, 1, 0, 0, 1, '1, 0, 30, 0);
    desel("R1 final", 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule